// File: doc/BRIEF.md
# GPIO Bank Edge Interrupt Collector with Debounce

This block is the pin-side interrupt logic of one GPIO bank. Every raw pin is first brought into the clock domain through a short flop chain. It can then pass through a debounce filter, which is controlled per pin. The filter accepts a new level only after the pin has held that level for a window of 2^n millisecond ticks. The tick comes from an external prescaler as a one-cycle pulse. The cleaned level is compared against its value in the previous cycle. Each pin selects which transition counts as an event: rising, falling, both, or none.

A detected event sets a sticky per-pin status bit. Software clears that bit by pulsing the matching bit of a write-one-to-clear strobe word. A single bank interrupt line is high while any status bit is pending whose mask bit is zero. Masking never stops status bits from being recorded. Register access and any write protection sit outside this block. The block receives the control fields, the mask and the clear strobe as plain inputs.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: After reset every status bit is 0 and the bank interrupt is low.
- R2: Trigger code 1 (per-pin control bits [1:0]) records only rising transitions of the cleaned level. A falling transition leaves the status bit unchanged.
- R3: Trigger code 2 records only falling transitions. A rising transition leaves the status bit unchanged.
- R4: Trigger code 3 records both rising and falling transitions.
- R5: Trigger code 0 records nothing, however the pin toggles.
- R6: With debounce off (per-pin control bit 5 = 0), a pin change is reflected in the status word at most 4 clock cycles after it is driven. This covers two synchroniser flops, the filter flop and the status flop. The exponent field is ignored in this case.
- R7: With debounce on, the exponent n in control bits [4:2] sets a window of 2^n consecutive millisecond ticks (1 to 128). The cleaned level follows the synchronised pin only after that many ticks at the new level.
- R8: With debounce on, a return of the synchronised pin to the current cleaned level restarts the count. Bounces shorter than the window produce no event.
- R9: Status bits are sticky until a 1 is pulsed on the matching clear bit. Clearing one bit leaves the other bits unchanged. An event after a clear sets the bit again.
- R10: When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: The interrupt is high exactly while some status bit is 1 with its mask bit at 0. A masked pin still sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw, asynchronous pin levels |
| pin_ctrl_i | input | NPINS*CTRL_W | Per-pin control: [1:0] trigger, [4:2] debounce exponent, [5] debounce enable; pin k at bits k*CTRL_W upward |
| mask_i | input | NPINS | 1 removes the pin from the interrupt aggregate |
| clr_i | input | NPINS | One-cycle write-one-to-clear strobe per status bit |
| ms_tick_i | input | 1 | One-cycle millisecond tick pulse |
| status_o | output | NPINS | Sticky per-pin event flags |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench builds the block with its defaults: 32 pins, a two-flop synchroniser and a 3-bit exponent. The 3-bit exponent lets the full 128-tick window and the widest debounce counter be exercised. The bench's own millisecond divider pulses the tick every 4 clock cycles. At that rate the 1-tick, 4-tick and 128-tick windows all complete within a few hundred cycles. Bounce trains shorter than the window can then be timed against a known tick rate.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Debounce exponent width; window spans 2^0 .. 2^(2^EXP_W - 1) ticks.
  localparam int DEF_EXP_W = 3;

  // Field positions inside one pin's control slice.
  localparam int TRIG_LSB = 0;
  localparam int TRIG_W   = 2;
  localparam int EXP_LSB  = TRIG_LSB + TRIG_W;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  // Decide whether a transition matches the selected trigger.
  function automatic logic edge_hit(trig_e t, logic rise, logic fall);
    case (t)
      TRIG_RISE: return rise;
      TRIG_FALL: return fall;
      TRIG_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  // Last counter value of a 2^e tick window.
  function automatic int unsigned window_last(int unsigned e);
    return (32'd1 << e) - 32'd1;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_debounce.sv
module gpio_pin_debounce
  import gpio_irq_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  input  logic             tick_i,
  input  logic             db_en_i,
  input  logic [EXP_W-1:0] db_exp_i,
  output logic             dout_o
);
  localparam int CNT_W = (2 ** EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_w;
  logic             filt_q;
  logic             differ_w;
  logic             expire_w;

  assign last_w   = CNT_W'(window_last(32'(db_exp_i)));
  assign differ_w = din_i ^ filt_q;
  assign expire_w = differ_w & tick_i & (cnt_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!db_en_i) begin
      filt_q <= din_i;
      cnt_q  <= '0;
    end else if (!differ_w) begin
      cnt_q  <= '0;
    end else if (expire_w) begin
      filt_q <= din_i;
      cnt_q  <= '0;
    end else if (tick_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign dout_o = filt_q;

  // R7: with the filter on, the level moves only on a tick.
  assert_db_tick_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(db_en_i) && (filt_q != $past(filt_q))) |-> $past(tick_i));

  // R8: while input agrees with the filtered level, the level holds.
  assert_db_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(db_en_i) && !$past(differ_w)) |-> $stable(filt_q));
endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic [1:0] trig_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_w = level_i & ~prev_q;
  assign fall_w = ~level_i & prev_q;
  assign hit_o  = edge_hit(trig_e'(trig_i), rise_w, fall_w);
endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int EXP_W       = DEF_EXP_W,
  localparam int CTRL_W     = TRIG_W + EXP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_i,
  input  logic [NPINS*CTRL_W-1:0] pin_ctrl_i,
  input  logic [NPINS-1:0]        mask_i,
  input  logic [NPINS-1:0]        clr_i,
  input  logic                    ms_tick_i,
  output logic [NPINS-1:0]        status_o,
  output logic                    irq_o
);
  localparam int DBEN_BIT = EXP_LSB + EXP_W;

  logic [NPINS-1:0] sync_w;
  logic [NPINS-1:0] clean_w;
  logic [NPINS-1:0] hit_w;
  logic [NPINS-1:0] status_q;

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [CTRL_W-1:0] ctrl_w;
      assign ctrl_w = pin_ctrl_i[p*CTRL_W +: CTRL_W];

      gpio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i[p]),
        .q_o   (sync_w[p])
      );

      gpio_pin_debounce #(.EXP_W(EXP_W)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .din_i    (sync_w[p]),
        .tick_i   (ms_tick_i),
        .db_en_i  (ctrl_w[DBEN_BIT]),
        .db_exp_i (ctrl_w[EXP_LSB +: EXP_W]),
        .dout_o   (clean_w[p])
      );

      gpio_edge_sense u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (clean_w[p]),
        .trig_i  (ctrl_w[TRIG_LSB +: TRIG_W]),
        .hit_o   (hit_w[p])
      );

      // R9: a set bit survives every cycle without a clear.
      assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[p] && !clr_i[p]) |=> status_q[p]);

      // R9: a clear with no coincident event drops the bit.
      assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[p] && !hit_w[p]) |=> !status_q[p]);

      // R10: an event always lands, clear or not.
      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_w[p] |=> status_q[p]);

      // R9: a bit only rises because of an event.
      assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[p]) |-> $past(hit_w[p]));

      // R11: an unmasked pending bit drives the interrupt.
      assert_irq_unmasked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[p] && !mask_i[p]) |-> irq_o);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_i) | hit_w;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ~mask_i);

  // R11: nothing pending means no interrupt.
  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_o);
endmodule

// File: tb/gpio_edge_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_bank_test;
  import gpio_irq_pkg::*;

  localparam int NPINS    = 32;
  localparam int EXP_W    = DEF_EXP_W;
  localparam int CTRL_W   = TRIG_W + EXP_W + 1;
  localparam int TICK_DIV = 4;

  typedef struct {
    logic [NPINS-1:0] st;
    logic             irq;
    string            tag;
  } sb_item_t;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NPINS-1:0]        pins = '0;
  logic [NPINS*CTRL_W-1:0] ctrl = '0;
  logic [NPINS-1:0]        mask = '0;
  logic [NPINS-1:0]        clr = '0;
  logic                    ms_tick = 1'b0;
  logic [NPINS-1:0]        status;
  logic                    irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  sb_item_t sb_q[$];
  event sb_done;

  always #4 clk = ~clk;

  gpio_edge_irq_bank uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pins),
    .pin_ctrl_i (ctrl),
    .mask_i     (mask),
    .clr_i      (clr),
    .ms_tick_i  (ms_tick),
    .status_o   (status),
    .irq_o      (irq)
  );

  // Millisecond prescaler stand-in.
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
      ms_tick = (tcnt == 0);
    end
  end

  // Monitor: pops expected items and compares away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (status !== it.st || irq !== it.irq) begin
          errors++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   it.tag, status, irq, it.st, it.irq);
        end
        -> sb_done;
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(logic [NPINS-1:0] st, logic ir, string tag);
    sb_item_t it;
    @(posedge clk);
    #1;
    it.st = st; it.irq = ir; it.tag = tag;
    sb_q.push_back(it);
    @(sb_done);
  endtask

  task automatic set_ctrl(int p, logic en, logic [EXP_W-1:0] e, trig_e t);
    ctrl[p*CTRL_W +: CTRL_W] = {en, e, t};
  endtask

  task automatic clear(logic [NPINS-1:0] m);
    @(negedge clk) clr = m;
    @(negedge clk) clr = '0;
  endtask

  initial begin
    set_ctrl(0, 1'b0, 3'd7, TRIG_RISE);
    set_ctrl(1, 1'b0, 3'd0, TRIG_FALL);
    set_ctrl(2, 1'b0, 3'd0, TRIG_BOTH);
    set_ctrl(3, 1'b0, 3'd0, TRIG_OFF);
    set_ctrl(4, 1'b1, 3'd2, TRIG_RISE);
    set_ctrl(5, 1'b1, 3'd0, TRIG_RISE);
    set_ctrl(6, 1'b1, 3'd7, TRIG_RISE);
    wait_cyc(5);
    rst_n = 1'b1;
    expect_st('0, 1'b0, "R1 reset state");

    // R2 and R6: rising with filter off (exponent 7 ignored).
    @(negedge clk) pins[0] = 1'b1;
    wait_cyc(4);
    expect_st(32'h1, 1'b1, "R2/R6 rising recorded");
    clear(32'h1);
    expect_st('0, 1'b0, "R9 clear");
    @(negedge clk) pins[0] = 1'b0;
    wait_cyc(5);
    expect_st('0, 1'b0, "R2 falling ignored");

    // R3 falling only.
    @(negedge clk) pins[1] = 1'b1;
    wait_cyc(5);
    expect_st('0, 1'b0, "R3 rising ignored");
    @(negedge clk) pins[1] = 1'b0;
    wait_cyc(5);
    expect_st(32'h2, 1'b1, "R3 falling recorded");

    // R11 mask, R4 both edges, R9 rearm.
    @(negedge clk) mask = 32'h2;
    expect_st(32'h2, 1'b0, "R11 masked bit held, irq low");
    @(negedge clk) pins[2] = 1'b1;
    wait_cyc(5);
    expect_st(32'h6, 1'b1, "R4 rising recorded");
    clear(32'h4);
    expect_st(32'h2, 1'b0, "R9 partial clear");
    @(negedge clk) pins[2] = 1'b0;
    wait_cyc(5);
    expect_st(32'h6, 1'b1, "R4/R9 falling sets again");
    clear(32'h6);
    @(negedge clk) mask = '0;
    expect_st('0, 1'b0, "R9 clear two bits");

    // R5 trigger off.
    @(negedge clk) pins[3] = 1'b1;
    wait_cyc(5);
    @(negedge clk) pins[3] = 1'b0;
    wait_cyc(5);
    expect_st('0, 1'b0, "R5 disabled pin silent");

    // R11 masked pin still records.
    @(negedge clk) mask = 32'h1;
    @(negedge clk) pins[0] = 1'b1;
    wait_cyc(5);
    expect_st(32'h1, 1'b0, "R11 masked pin records status");
    clear(32'h1);
    @(negedge clk) begin pins[0] = 1'b0; mask = '0; end
    wait_cyc(5);
    expect_st('0, 1'b0, "R11 cleared masked bit");

    // R10: clear and event in the same cycle (event lands at 4th edge).
    @(negedge clk) pins[2] = 1'b1;
    wait_cyc(3);
    clr = 32'h4;
    @(negedge clk) clr = '0;
    expect_st(32'h4, 1'b1, "R10 set wins over clear");
    clear(32'h4);

    // R7: 4-tick window on pin 4.
    @(negedge clk) pins[4] = 1'b1;
    wait_cyc(8);
    expect_st('0, 1'b0, "R7 window not yet elapsed");
    wait_cyc(24);
    expect_st(32'h10, 1'b1, "R7 window elapsed");
    clear(32'h10);

    // R8: bounces shorter than the window are swallowed.
    set_ctrl(4, 1'b1, 3'd2, TRIG_BOTH);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk) pins[4] = 1'b0;
      wait_cyc(7);
      @(negedge clk) pins[4] = 1'b1;
      wait_cyc(7);
    end
    wait_cyc(40);
    expect_st('0, 1'b0, "R8 bounce train ignored");
    @(negedge clk) pins[4] = 1'b0;
    wait_cyc(40);
    expect_st(32'h10, 1'b1, "R8 settled low recorded");
    clear(32'h10);

    // R7: single-tick window.
    @(negedge clk) pins[5] = 1'b1;
    wait_cyc(10);
    expect_st(32'h20, 1'b1, "R7 1-tick window");
    clear(32'h20);

    // R7: 128-tick window.
    @(negedge clk) pins[6] = 1'b1;
    wait_cyc(480);
    expect_st('0, 1'b0, "R7 128-tick window early");
    wait_cyc(60);
    expect_st(32'h40, 1'b1, "R7 128-tick window elapsed");
    clear(32'h40);

    // R11 aggregate of two pins, R9 partial clear.
    @(negedge clk) begin pins[0] = 1'b1; pins[2] = 1'b0; end
    wait_cyc(5);
    expect_st(32'h5, 1'b1, "R11 two pins pending");
    clear(32'h1);
    expect_st(32'h4, 1'b1, "R9 other bit kept");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule